// File: doc/BRIEF.md
# Floating-Point Unit Error and Control-Status Registers

This block holds the two 32-bit status registers of a floating-point co-processor. The error/operation register captures the first error number since it was last cleared, shows whether the unit is busy, and flags whether any command has been issued. It also keeps fourteen bits of the most recent command. The control/status register holds the last comparison flags, the sticky exception flags, a trap enable for each exception, and the dynamic rounding mode.

A host writes and reads either register through one port, using `host_sel` to choose between them. The datapaths report exception pulses, comparison results, invalid commands and command issue. The block drives the current rounding mode and the condition flags back to them. It also produces a registered error pulse with a 3-bit error code, which the unit uses to stop pending work.

Bit indices below are vector indices, with bit 31 as the most significant bit.

Top module: `fpu_stat_regs`

## Requirements
- R1: After reset, both registers read 0, `rnd_mode` is 0 and `err_pulse` is low.
- R2: The error/operation register reads back with the error number in [31:29], the live `busy` input in [15], the issued flag in [14] and `cmd_word[15:2]` of the latest issued command in [13:0]. All other bits read 0. A `cmd_issue` sets [14] and loads [13:0].
- R3: Writing 0 to the error/operation register clears the error number, the issued flag and the command field. Writing any nonzero value raises error 3 and leaves the register unchanged.
- R4: Once the error number is nonzero, a later error does not replace it. Only a clear changes it.
- R5: While `unit_en` is low, and in any cycle with `cfg_wr` high, the error/operation register is forced to 0. This takes priority over every same-cycle event. Errors are not raised while `unit_en` is low.
- R6: In the control/status register, [31:28] hold the comparison flags. [26:22] hold the sticky flags for overflow, underflow, inexact, divide-by-zero and invalid, from bit 26 down to bit 22. [10:6] hold the enables in the same order, and [1:0] hold the rounding mode. A write with any bit of [15:11] or [5:2] set raises error 3 and changes nothing.
- R7: On an accepted control/status write, bits [27] and [21:16] are ignored and always read back as 0.
- R8: `exc_pulse[4:0]` (overflow, underflow, inexact, divide-by-zero, invalid) ORs into the sticky flags. Only an accepted host write lowers a sticky flag. A pulse in the same cycle as that write is still kept.
- R9: An exception pulse whose enable is 1 raises error 1. An exception whose enable is 0 raises nothing. The enables used are those held before the cycle.
- R10: `rnd_mode` equals control/status bits [1:0]: 0 is nearest-even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity.
- R11: `cmp_valid` loads `cmp_flags` into [31:28] and `cond_flags`. If a host write arrives in the same cycle, the comparison wins this field.
- R12: A raised error gives a one-cycle `err_pulse` one clock later, with its number on `err_code`. `cmd_invalid` raises error 2. When several errors arise together, the lowest number is reported and recorded.
- R13: If a zero write to the error/operation register coincides with a command issue or a new error, the new event is recorded after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Unit enabled; low clears the error register |
| cfg_wr | input | 1 | Configuration change strobe; clears the error register |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects error/operation, 1 selects control/status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read-back of the selected register |
| exc_pulse | input | 5 | Exception pulses: overflow, underflow, inexact, divide-by-zero, invalid |
| cmp_valid | input | 1 | Comparison result valid |
| cmp_flags | input | 4 | Comparison flags |
| cmd_issue | input | 1 | Command issue strobe |
| cmd_word | input | 32 | Issued command word |
| cmd_invalid | input | 1 | Invalid command detected |
| busy | input | 1 | Unit busy |
| rnd_mode | output | 2 | Dynamic rounding mode |
| cond_flags | output | 4 | Current comparison flags |
| err_pulse | output | 1 | Error raised (one cycle) |
| err_code | output | 3 | Number of the raised error |

## Verification
The interesting collisions are a clear of the error/operation register landing in the same cycle as a command issue or an invalid command. The same applies to a control/status write landing with an exception pulse or a comparison result. The bench drives each pair in a single cycle and reads back at the next falling edge. It expects the issue, error or pulse to survive the clear. It also expects the trap decision to follow the enables held before the write. Colliding errors of different numbers are driven together, and the bench checks that the lower number is both pulsed and kept.

// File: rtl/fpu_stat_regs.sv
module fpu_stat_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unit_en,
  input  logic        cfg_wr,
  input  logic        host_wr,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic [4:0]  exc_pulse,
  input  logic        cmp_valid,
  input  logic [3:0]  cmp_flags,
  input  logic        cmd_issue,
  input  logic [31:0] cmd_word,
  input  logic        cmd_invalid,
  input  logic        busy,
  output logic [1:0]  rnd_mode,
  output logic [3:0]  cond_flags,
  output logic        err_pulse,
  output logic [2:0]  err_code
);

  localparam logic [31:0] CSR_ZERO_MASK = 32'h0000_F83C;

  logic [2:0]  err_num;
  logic        issued;
  logic [13:0] last_cmd;
  logic [3:0]  cmp_q;
  logic [4:0]  sticky_q;
  logic [4:0]  en_q;
  logic [1:0]  rnd_q;

  wire err_wr     = host_wr & ~host_sel;
  wire csr_wr     = host_wr & host_sel;
  wire err_clear  = err_wr & ~|host_wdata;
  wire err_wr_bad = err_wr & |host_wdata;
  wire csr_wr_bad = csr_wr & |(host_wdata & CSR_ZERO_MASK);
  wire csr_wr_ok  = csr_wr & ~|(host_wdata & CSR_ZERO_MASK);
  wire wipe       = ~unit_en | cfg_wr;

  wire raise_fpe  = unit_en & |(exc_pulse & en_q);
  wire raise_cmd  = unit_en & cmd_invalid;
  wire raise_stat = unit_en & (err_wr_bad | csr_wr_bad);

  logic [2:0] new_code;
  always_comb begin
    if (raise_fpe)       new_code = 3'd1;
    else if (raise_cmd)  new_code = 3'd2;
    else if (raise_stat) new_code = 3'd3;
    else                 new_code = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      err_num  <= 3'd0;
      issued   <= 1'b0;
      last_cmd <= 14'd0;
    end else begin
      if (err_num == 3'd0 || err_clear)
        err_num <= new_code;
      issued <= cmd_issue | (issued & ~err_clear);
      if (cmd_issue)
        last_cmd <= cmd_word[15:2];
      else if (err_clear)
        last_cmd <= 14'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= 4'd0;
      sticky_q <= 5'd0;
      en_q     <= 5'd0;
      rnd_q    <= 2'd0;
    end else begin
      sticky_q <= (csr_wr_ok ? host_wdata[26:22] : sticky_q) | exc_pulse;
      if (cmp_valid)
        cmp_q <= cmp_flags;
      else if (csr_wr_ok)
        cmp_q <= host_wdata[31:28];
      if (csr_wr_ok) begin
        en_q  <= host_wdata[10:6];
        rnd_q <= host_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_code  <= 3'd0;
    end else begin
      err_pulse <= new_code != 3'd0;
      err_code  <= new_code;
    end
  end

  wire [31:0] err_view = {err_num, 13'd0, busy, issued, last_cmd};
  wire [31:0] csr_view = {cmp_q, 1'b0, sticky_q, 11'd0, en_q, 4'd0, rnd_q};

  assign host_rdata = host_sel ? csr_view : err_view;
  assign rnd_mode   = rnd_q;
  assign cond_flags = cmp_q;

  assert_first_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_num != 3'd0 && unit_en && !cfg_wr && !err_clear) |=> $stable(err_num));

  assert_wipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_en) |=> (err_num == 3'd0 && !issued && last_cmd == 14'd0));

  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && unit_en && !cfg_wr) |=> issued);

  assert_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && |(exc_pulse & en_q)) |=> (err_pulse && err_code == 3'd1));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_wr_ok) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  assert_bad_csr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && csr_wr_bad && !cmp_valid) |=> (err_pulse && $stable(rnd_q) && $stable(en_q) && $stable(cmp_q)));

  assert_pulse_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_code != 3'd0));

endmodule

// File: tb/fpu_stat_regs_test.sv
`timescale 1ns/1ps
module fpu_stat_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unit_en = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [4:0]  exc_pulse = '0;
  logic        cmp_valid = 1'b0;
  logic [3:0]  cmp_flags = '0;
  logic        cmd_issue = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_invalid = 1'b0;
  logic        busy = 1'b0;
  logic [1:0]  rnd_mode;
  logic [3:0]  cond_flags;
  logic        err_pulse;
  logic [2:0]  err_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpu_stat_regs uut (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cfg_wr(cfg_wr),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .exc_pulse(exc_pulse), .cmp_valid(cmp_valid),
    .cmp_flags(cmp_flags), .cmd_issue(cmd_issue), .cmd_word(cmd_word),
    .cmd_invalid(cmd_invalid), .busy(busy), .rnd_mode(rnd_mode),
    .cond_flags(cond_flags), .err_pulse(err_pulse), .err_code(err_code)
  );

  localparam int NV = 12;
  localparam logic [31:0] V_WR [NV] = '{
    32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'hF7C0_07C3,
    32'hFFFF_07C3, 32'h0000_0800, 32'h0000_0004, 32'h0000_0000,
    32'h5000_0040, 32'h0000_8000, 32'h0800_0000, 32'h8040_0081};
  localparam logic [31:0] V_RD [NV] = '{
    32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'hF7C0_07C3,
    32'hF7C0_07C3, 32'hF7C0_07C3, 32'hF7C0_07C3, 32'h0000_0000,
    32'h5000_0040, 32'h5000_0040, 32'h0000_0000, 32'h8040_0081};
  localparam logic [2:0] V_CODE [NV] = '{
    3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd3, 3'd0, 3'd0, 3'd3, 3'd0, 3'd0};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
    host_wr = 1'b0; exc_pulse = '0; cmp_valid = 1'b0; cmd_issue = 1'b0;
    cmd_invalid = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
    host_sel = sel;
    #0.5;
    chk(host_rdata, exp, tag);
  endtask

  task automatic pulse_chk(input logic [2:0] code, input string tag);
    chk({31'd0, err_pulse}, {31'd0, code != 3'd0}, tag);
    if (code != 3'd0) chk({29'd0, err_code}, {29'd0, code}, tag);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, 32'h0, "R1 err reg after reset");
    rd(1'b1, 32'h0, "R1 csr after reset");
    chk({30'd0, rnd_mode}, 32'd0, "R1 rnd_mode after reset");
    chk({31'd0, err_pulse}, 32'd0, "R1 err_pulse after reset");

    for (int i = 0; i < NV; i++) begin
      wr(1'b1, V_WR[i]);
      cyc;
      rd(1'b1, V_RD[i], $sformatf("R6/R7 csr vector %0d", i));
      pulse_chk(V_CODE[i], $sformatf("R6 pulse vector %0d", i));
    end
    chk({30'd0, rnd_mode}, 32'd1, "R10 rnd_mode toward zero");
    chk({28'd0, cond_flags}, 32'd8, "R11 cond_flags from write");
    rd(1'b0, 32'h6000_0000, "R4 first error is 3");

    exc_pulse = 5'b00010;
    cyc;
    pulse_chk(3'd1, "R9 enabled divide-by-zero traps");
    rd(1'b0, 32'h6000_0000, "R4 error 3 kept over error 1");
    rd(1'b1, 32'h80C0_0081, "R8 sticky divide-by-zero set");

    exc_pulse = 5'b10000;
    cyc;
    pulse_chk(3'd0, "R9 masked overflow no trap");
    rd(1'b1, 32'h84C0_0081, "R8 sticky overflow set");

    busy = 1'b1;
    rd(1'b0, 32'h6000_8000, "R2 busy read-back");
    busy = 1'b0;

    wr(1'b0, 32'h0000_0001);
    cyc;
    pulse_chk(3'd3, "R3 nonzero error write");
    rd(1'b0, 32'h6000_0000, "R3 nonzero write no change");

    wr(1'b0, 32'h0);
    cyc;
    pulse_chk(3'd0, "R3 zero write no error");
    rd(1'b0, 32'h0, "R3 zero write clears");

    cmd_issue = 1'b1; cmd_word = 32'h0001_ABCD;
    cyc;
    rd(1'b0, 32'h0000_6AF3, "R2 issued flag and command bits");

    wr(1'b0, 32'h0); cmd_issue = 1'b1; cmd_word = 32'h0000_FFFF;
    cyc;
    rd(1'b0, 32'h0000_7FFF, "R13 clear with issue");

    wr(1'b0, 32'h0); cmd_invalid = 1'b1;
    cyc;
    pulse_chk(3'd2, "R12 invalid command error 2");
    rd(1'b0, 32'h4000_0000, "R13 clear with new error");

    wr(1'b0, 32'h0);
    cyc;
    cmd_invalid = 1'b1; exc_pulse = 5'b00010;
    cyc;
    pulse_chk(3'd1, "R12 lowest number wins");
    rd(1'b0, 32'h2000_0000, "R12 lowest number recorded");

    wr(1'b1, 32'h0); exc_pulse = 5'b00001;
    cyc;
    pulse_chk(3'd0, "R9 old enables mask invalid");
    rd(1'b1, 32'h0040_0000, "R8 pulse survives csr write");
    chk({30'd0, rnd_mode}, 32'd0, "R10 rnd_mode nearest even");

    wr(1'b1, 32'h5000_0002); cmp_valid = 1'b1; cmp_flags = 4'hA;
    cyc;
    rd(1'b1, 32'hA000_0002, "R11 comparison beats write");
    chk({28'd0, cond_flags}, 32'hA, "R11 cond_flags");
    chk({30'd0, rnd_mode}, 32'd2, "R10 rnd_mode toward +inf");

    cmp_valid = 1'b1; cmp_flags = 4'h3;
    cyc;
    rd(1'b1, 32'h3000_0002, "R11 comparison alone");

    cmd_issue = 1'b1; cmd_word = 32'h4;
    cyc;
    rd(1'b0, 32'h2000_4001, "R2 issue after error");
    unit_en = 1'b0; cmd_invalid = 1'b1;
    cyc;
    pulse_chk(3'd0, "R5 no error while disabled");
    unit_en = 1'b1;
    rd(1'b0, 32'h0, "R5 disable clears");

    cmd_issue = 1'b1; cmd_word = 32'h4;
    cyc;
    cfg_wr = 1'b1; cmd_issue = 1'b1; cmd_word = 32'h8;
    cyc;
    rd(1'b0, 32'h0, "R5 config change wins");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule